// File: doc/BRIEF.md
# Serial Receiver with Per-Character Error Tagging

This block turns an asynchronous serial line into a stream of stored characters. It oversamples the line on a single-cycle tick that arrives sixteen times per bit period. A frame starts with a falling edge, and the start bit must still be low at its midpoint. After that, every data bit, the parity bit and each stop bit are sampled at their centre. The frame shape comes from a line-configuration byte and can change at run time: 5 to 8 data bits, optional parity with even or odd sense, and one or two stop bits.

Every finished frame is written into a receive queue together with four tags: framing error, parity error, break and overrun. The host reads one 12-bit word per character, and one pop input advances the queue. Two status bits report whether the queue is empty or full. With queueing disabled, the storage behaves as a single holding register. The block receives only while the global enable and the receive enable in the control word are both set.

Top module: `uart_rx_tagged`

## Requirements
- R1: After reset the queue is empty: `rx_status` reads 8'h10, with bit 4 meaning empty and bit 6 meaning full. Empty and full are never set together.
- R2: With 8 data bits, no parity and one stop bit (`line_cfg` bits [6:5]=11), a correct frame is stored as `rd_word` = {4'b0000, character}. The character sits in bits [7:0] and was received least-significant bit first.
- R3: `line_cfg` bits [6:5] select the word length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Unused high bits of `rd_word[7:0]` read as zero.
- R4: `line_cfg` bit 1 enables a parity bit after the data, and bit 2 selects even parity when set and odd parity when clear. A parity mismatch sets `rd_word` bit 9.
- R5: `line_cfg` bit 3 adds a second stop bit. A frame with both stop bits high is stored clean, and a low second stop bit sets `rd_word` bit 8.
- R6: A low stop bit sets the framing flag, `rd_word` bit 8, and the data is still stored.
- R7: If the line stays low through the whole frame, including the stop bit, exactly one entry 12'h500 is stored: a zero character with bit 8 (framing) and bit 10 (break) set. No new frame starts until the line has returned high.
- R8: A low pulse that is gone by the middle of the start bit (the 8th tick) stores nothing.
- R9: The queue holds DEPTH entries (16 or 32) when `line_cfg` bit 4 is set. When it is full, status bit 6 is set, a further character is discarded, and bit 11 (overrun) is set on the most recently stored entry.
- R10: With `line_cfg` bit 4 clear, the storage holds a single character. It reads full after one character, and a second character marks that entry with overrun.
- R11: Unless `ctrl_cfg` bit 0 and bit 9 are both set, no frame is received and the status does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse, sixteen per bit period |
| rx_in | input | 1 | Serial line, idle high |
| ctrl_cfg | input | 16 | Control word: bit 0 global enable, bit 9 receive enable |
| line_cfg | input | 8 | Frame format and queue enable (see R3 to R5, R9, R10) |
| rd_pop | input | 1 | Removes the head entry on the next clock edge |
| rd_word | output | 12 | Head entry: character [7:0], flags [11:8] |
| rx_status | output | 8 | Bit 4 empty, bit 6 full, other bits zero |

## Verification
The line passes through a two-stage synchronizer. The sampler then registers the finished character one clock after the tick that samples the last stop bit at its centre, and the queue count and status bits update on the clock after that. All of this lands roughly half a bit period before the stimulus task releases the line to idle. The bench therefore checks `rd_word` and `rx_status` only after a full trailing idle bit time, which is far beyond that latency. Reads are show-ahead: the head word is compared at a falling edge, and the pop takes effect on the following rising edge. Faulty stop bits are driven low for only 10 ticks, so the tail of a bad frame cannot be taken for a new start bit.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP1,
    RX_STOP2,
    RX_WAIT_HI
  } rx_state_e;

  // Character as produced by the sampler, before the overrun tag is added
  typedef struct packed {
    logic       brk;
    logic       par_err;
    logic       frm_err;
    logic [7:0] data;
  } rx_char_t;

  localparam int unsigned CHAR_W  = 11;
  localparam int unsigned ENTRY_W = 12;

  // Line-configuration bit positions
  localparam int unsigned LC_PEN  = 1;
  localparam int unsigned LC_EPS  = 2;
  localparam int unsigned LC_STP2 = 3;
  localparam int unsigned LC_FEN  = 4;
  localparam int unsigned LC_WL_L = 5;

  // Control-word bit positions
  localparam int unsigned CC_ON   = 0;
  localparam int unsigned CC_RXON = 9;

endpackage

// File: rtl/uart_rx_rst_sync.sv
module uart_rx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '1;
    else        pipe_q <= {pipe_q[STAGES-2:0], din};
  end

  assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler
  import uart_rx_pkg::*;
#(
  parameter int unsigned OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_on,
  input  logic       tick,
  input  logic       line_s,
  input  logic [7:0] lcfg,
  output logic       out_vld,
  output rx_char_t   out_char
);
  localparam int unsigned CNTW = $clog2(OSR);
  localparam logic [CNTW-1:0] CNT_MID  = CNTW'(OSR/2 - 1);
  localparam logic [CNTW-1:0] CNT_LAST = CNTW'(OSR - 1);

  rx_state_e       st_q, st_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic [2:0]      idx_q, idx_d;
  logic [7:0]      sh_q, sh_d;
  logic            par_q, par_d;
  logic            vld_q, vld_d;
  rx_char_t        chr_q, chr_d;

  logic       pen, eps, stp2;
  logic [2:0] last_idx;
  logic       samp;
  logic       par_bad;
  logic       is_brk;

  assign pen      = lcfg[LC_PEN];
  assign eps      = lcfg[LC_EPS];
  assign stp2     = lcfg[LC_STP2];
  assign last_idx = 3'd4 + {1'b0, lcfg[LC_WL_L+1:LC_WL_L]};
  assign samp     = tick && (cnt_q == CNT_LAST);
  assign par_bad  = pen && ((^sh_q) ^ par_q ^ ~eps);
  assign is_brk   = (sh_q == 8'h00) && (!pen || !par_q);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    idx_d = idx_q;
    sh_d  = sh_q;
    par_d = par_q;
    vld_d = 1'b0;
    chr_d = chr_q;
    if (!rx_on) begin
      st_d  = RX_IDLE;
      cnt_d = '0;
    end else begin
      if (tick && st_q != RX_IDLE && st_q != RX_WAIT_HI) cnt_d = cnt_q + 1'b1;
      unique case (st_q)
        RX_IDLE: begin
          if (tick && !line_s) begin
            st_d  = RX_START;
            cnt_d = '0;
          end
        end
        RX_START: begin
          if (tick && cnt_q == CNT_MID) begin
            cnt_d = '0;
            idx_d = '0;
            sh_d  = '0;
            par_d = 1'b0;
            st_d  = line_s ? RX_IDLE : RX_DATA;
          end
        end
        RX_DATA: begin
          if (samp) begin
            sh_d[idx_q] = line_s;
            cnt_d       = '0;
            if (idx_q == last_idx) st_d = pen ? RX_PAR : RX_STOP1;
            else                   idx_d = idx_q + 1'b1;
          end
        end
        RX_PAR: begin
          if (samp) begin
            par_d = line_s;
            cnt_d = '0;
            st_d  = RX_STOP1;
          end
        end
        RX_STOP1: begin
          if (samp) begin
            cnt_d = '0;
            if (!line_s) begin
              vld_d         = 1'b1;
              chr_d.data    = sh_q;
              chr_d.frm_err = 1'b1;
              chr_d.brk     = is_brk;
              chr_d.par_err = is_brk ? 1'b0 : par_bad;
              st_d          = is_brk ? RX_WAIT_HI : RX_IDLE;
            end else if (stp2) begin
              st_d = RX_STOP2;
            end else begin
              vld_d         = 1'b1;
              chr_d.data    = sh_q;
              chr_d.frm_err = 1'b0;
              chr_d.brk     = 1'b0;
              chr_d.par_err = par_bad;
              st_d          = RX_IDLE;
            end
          end
        end
        RX_STOP2: begin
          if (samp) begin
            cnt_d         = '0;
            vld_d         = 1'b1;
            chr_d.data    = sh_q;
            chr_d.frm_err = !line_s;
            chr_d.brk     = 1'b0;
            chr_d.par_err = par_bad;
            st_d          = RX_IDLE;
          end
        end
        RX_WAIT_HI: begin
          if (line_s) st_d = RX_IDLE;
        end
        default: st_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RX_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
      sh_q  <= '0;
      par_q <= 1'b0;
      vld_q <= 1'b0;
      chr_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      idx_q <= idx_d;
      sh_q  <= sh_d;
      par_q <= par_d;
      vld_q <= vld_d;
      if (vld_d) chr_q <= chr_d;
    end
  end

  assign out_vld  = vld_q;
  assign out_char = chr_q;
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fifo_en,
  input  logic               push,
  input  logic [CHAR_W-1:0]  push_word,
  input  logic               pop,
  output logic [ENTRY_W-1:0] head_word,
  output logic               empty,
  output logic               full
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [AW-1:0]      wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0]      cnt_q, cnt_d;
  logic [CW-1:0]      cap;
  logic [AW-1:0]      last_ptr;
  logic               wr_ok, mark_ovr, pop_ok;

  assign cap      = fifo_en ? CW'(DEPTH) : CW'(1);
  assign empty    = (cnt_q == '0);
  assign full     = (cnt_q >= cap);
  assign wr_ok    = push && !full;
  assign mark_ovr = push && full && !empty;
  assign pop_ok   = pop && !empty;
  assign last_ptr = wr_q - 1'b1;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (wr_ok)  wr_d = wr_q + 1'b1;
    if (pop_ok) rd_d = rd_q + 1'b1;
    case ({wr_ok, pop_ok})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok)         mem[wr_q] <= {1'b0, push_word};
    else if (mark_ovr) mem[last_ptr][ENTRY_W-1] <= 1'b1;
  end

  assign head_word = empty ? '0 : mem[rd_q];
endmodule

// File: rtl/uart_rx_tagged.sv
module uart_rx_tagged
  import uart_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned OSR   = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        baud_tick,
  input  logic        rx_in,
  input  logic [15:0] ctrl_cfg,
  input  logic [7:0]  line_cfg,
  input  logic        rd_pop,
  output logic [11:0] rd_word,
  output logic [7:0]  rx_status
);
  logic     rst_core_n;
  logic     line_s;
  logic     rx_on;
  logic     samp_vld;
  rx_char_t samp_char;
  logic     push;
  logic     q_empty, q_full;
  logic [7:0] samp_data;
  logic       samp_fe, samp_brk;

  assign rx_on     = ctrl_cfg[CC_ON] && ctrl_cfg[CC_RXON];
  assign push      = samp_vld && rx_on;
  assign samp_data = samp_char.data;
  assign samp_fe   = samp_char.frm_err;
  assign samp_brk  = samp_char.brk;

  uart_rx_rst_sync #(.STAGES(2)) rst_i (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_core_n)
  );

  uart_rx_sync #(.STAGES(2)) sync_i (
    .clk(clk), .rst_n(rst_core_n), .din(rx_in), .dout(line_s)
  );

  uart_rx_sampler #(.OSR(OSR)) samp_i (
    .clk(clk), .rst_n(rst_core_n), .rx_on(rx_on), .tick(baud_tick),
    .line_s(line_s), .lcfg(line_cfg), .out_vld(samp_vld), .out_char(samp_char)
  );

  uart_rx_fifo #(.DEPTH(DEPTH)) fifo_i (
    .clk(clk), .rst_n(rst_core_n), .fifo_en(line_cfg[LC_FEN]),
    .push(push), .push_word(samp_char), .pop(rd_pop),
    .head_word(rd_word), .empty(q_empty), .full(q_full)
  );

  assign rx_status = {1'b0, q_full, 1'b0, q_empty, 4'b0000};
endmodule

// File: rtl/uart_rx_tagged_chk.sv
module uart_rx_tagged_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_on,
  input logic       rd_pop,
  input logic [7:0] rx_status,
  input logic [7:0] line_cfg,
  input logic       push_vld,
  input logic [7:0] push_data,
  input logic       push_fe,
  input logic       push_brk
);
  AST_EMPTY_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_status[4] && rx_status[6])); // R1

  AST_EMPTY_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_status[4] && push_vld && rx_on) |=> !rx_status[4]); // R2

  AST_SHORT_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (push_vld && line_cfg[6:5] == 2'b00) |-> (push_data[7:5] == 3'b000)); // R3

  AST_BREAK_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (push_vld && push_brk) |-> (push_fe && push_data == 8'h00)); // R7

  AST_FULL_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_status[6] && !rd_pop && $stable(line_cfg)) |=> rx_status[6]); // R9

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_on && !rd_pop && $stable(line_cfg)) |=> $stable(rx_status)); // R11
endmodule

bind uart_rx_tagged uart_rx_tagged_chk chk_i (
  .clk(clk), .rst_n(rst_core_n), .rx_on(rx_on), .rd_pop(rd_pop),
  .rx_status(rx_status), .line_cfg(line_cfg), .push_vld(samp_vld),
  .push_data(samp_data), .push_fe(samp_fe), .push_brk(samp_brk)
);

// File: tb/uart_rx_tagged_tb_top.sv
module uart_rx_tagged_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int OSR        = 16;
  localparam int BIT_CLKS   = TICK_DIV * OSR;
  localparam int DEPTH      = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        baud_tick = 1'b0;
  logic        rx_in = 1'b1;
  logic [15:0] ctrl_cfg = 16'h0301;
  logic [7:0]  line_cfg = 8'h70;
  logic        rd_pop = 1'b0;
  logic [11:0] rd_word;
  logic [7:0]  rx_status;

  int n_chk = 0;
  int n_bad = 0;
  int tdiv = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    tdiv      <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
    baud_tick <= (tdiv == 0);
  end

  uart_rx_tagged #(.DEPTH(DEPTH), .OSR(OSR)) dut_i (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rx_in(rx_in),
    .ctrl_cfg(ctrl_cfg), .line_cfg(line_cfg), .rd_pop(rd_pop),
    .rd_word(rd_word), .rx_status(rx_status)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] lcfg(input logic [1:0] wl, input bit fen,
                                      input bit stp2, input bit eps, input bit pen);
    return {1'b0, wl, fen, stp2, eps, pen, 1'b0};
  endfunction

  task automatic hold(input logic v, input int clks);
    rx_in = v;
    repeat (clks) @(negedge clk);
  endtask

  // Frame: start, nb data bits LSB first, optional parity, stop bits, one idle bit
  task automatic send(input logic [7:0] d, input int nb, input bit pen, input bit eps,
                      input bit flip_par, input bit two, input bit s1, input bit s2);
    logic p;
    p = 1'b0;
    hold(1'b0, BIT_CLKS);
    for (int i = 0; i < nb; i++) begin
      p ^= d[i];
      hold(d[i], BIT_CLKS);
    end
    if (pen) hold((eps ? p : ~p) ^ flip_par, BIT_CLKS);
    if (s1) hold(1'b1, BIT_CLKS);
    else begin hold(1'b0, 10 * TICK_DIV); hold(1'b1, BIT_CLKS - 10 * TICK_DIV); end
    if (two && s1) begin
      if (s2) hold(1'b1, BIT_CLKS);
      else begin hold(1'b0, 10 * TICK_DIV); hold(1'b1, BIT_CLKS - 10 * TICK_DIV); end
    end
    hold(1'b1, BIT_CLKS);
  endtask

  task automatic pop_expect(input string req, input logic [11:0] exp);
    check({req, " not empty"}, 32'(rx_status[4]), 32'd0);
    check({req, " word"}, 32'(rd_word), 32'(exp));
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 reset status", 32'(rx_status), 32'h10);
  endtask

  task automatic t_basic();
    line_cfg = lcfg(2'b11, 1, 0, 0, 0);
    send(8'hA5, 8, 0, 0, 0, 0, 1, 1);
    send(8'h3C, 8, 0, 0, 0, 0, 1, 1);
    pop_expect("R2 8N1 first", 12'h0A5);
    pop_expect("R2 8N1 second", 12'h03C);
    check("R2 drained", 32'(rx_status), 32'h10);
  endtask

  task automatic t_wordlen();
    line_cfg = lcfg(2'b00, 1, 0, 0, 0);
    send(8'hF3, 5, 0, 0, 0, 0, 1, 1);
    pop_expect("R3 5-bit", 12'h013);
    line_cfg = lcfg(2'b01, 1, 0, 0, 0);
    send(8'hF3, 6, 0, 0, 0, 0, 1, 1);
    pop_expect("R3 6-bit", 12'h033);
    line_cfg = lcfg(2'b10, 1, 0, 0, 0);
    send(8'hF3, 7, 0, 0, 0, 0, 1, 1);
    pop_expect("R3 7-bit", 12'h073);
  endtask

  task automatic t_parity();
    line_cfg = lcfg(2'b11, 1, 0, 1, 1);
    send(8'h5A, 8, 1, 1, 0, 0, 1, 1);
    pop_expect("R4 even good", 12'h05A);
    send(8'h5B, 8, 1, 1, 1, 0, 1, 1);
    pop_expect("R4 even bad", 12'h25B);
    line_cfg = lcfg(2'b11, 1, 0, 0, 1);
    send(8'h07, 8, 1, 0, 0, 0, 1, 1);
    pop_expect("R4 odd good", 12'h007);
    send(8'h06, 8, 1, 0, 1, 0, 1, 1);
    pop_expect("R4 odd bad", 12'h206);
  endtask

  task automatic t_stop2();
    line_cfg = lcfg(2'b11, 1, 1, 0, 0);
    send(8'h81, 8, 0, 0, 0, 1, 1, 1);
    pop_expect("R5 two stops good", 12'h081);
    send(8'h42, 8, 0, 0, 0, 1, 1, 0);
    pop_expect("R5 second stop low", 12'h142);
    check("R5 drained", 32'(rx_status), 32'h10);
  endtask

  task automatic t_framing();
    line_cfg = lcfg(2'b11, 1, 0, 0, 0);
    send(8'hC3, 8, 0, 0, 0, 0, 0, 1);
    pop_expect("R6 stop low", 12'h1C3);
    check("R6 single entry", 32'(rx_status), 32'h10);
  endtask

  task automatic t_break();
    line_cfg = lcfg(2'b11, 1, 0, 0, 0);
    hold(1'b0, 11 * BIT_CLKS);
    hold(1'b1, 2 * BIT_CLKS);
    pop_expect("R7 break entry", 12'h500);
    check("R7 only one entry", 32'(rx_status), 32'h10);
  endtask

  task automatic t_glitch();
    line_cfg = lcfg(2'b11, 1, 0, 0, 0);
    hold(1'b0, 4 * TICK_DIV);
    hold(1'b1, 2 * BIT_CLKS);
    check("R8 glitch ignored", 32'(rx_status), 32'h10);
  endtask

  task automatic t_overrun();
    line_cfg = lcfg(2'b11, 1, 0, 0, 0);
    for (int i = 0; i < DEPTH; i++) send(8'(i + 1), 8, 0, 0, 0, 0, 1, 1);
    check("R9 full status", 32'(rx_status), 32'h40);
    send(8'hEE, 8, 0, 0, 0, 0, 1, 1);
    check("R9 still full", 32'(rx_status), 32'h40);
    for (int i = 0; i < DEPTH; i++)
      pop_expect("R9 drain", (i == DEPTH - 1) ? (12'h800 | 12'(i + 1)) : 12'(i + 1));
    check("R9 drained", 32'(rx_status), 32'h10);
  endtask

  task automatic t_holding();
    line_cfg = lcfg(2'b11, 0, 0, 0, 0);
    send(8'h11, 8, 0, 0, 0, 0, 1, 1);
    check("R10 full after one", 32'(rx_status), 32'h40);
    send(8'h22, 8, 0, 0, 0, 0, 1, 1);
    pop_expect("R10 overrun mark", 12'h811);
    check("R10 drained", 32'(rx_status), 32'h10);
  endtask

  task automatic t_disabled();
    line_cfg = lcfg(2'b11, 1, 0, 0, 0);
    ctrl_cfg = 16'h0001;
    send(8'h55, 8, 0, 0, 0, 0, 1, 1);
    check("R11 rx enable clear", 32'(rx_status), 32'h10);
    ctrl_cfg = 16'h0200;
    send(8'h66, 8, 0, 0, 0, 0, 1, 1);
    check("R11 global enable clear", 32'(rx_status), 32'h10);
    ctrl_cfg = 16'h0201;
    send(8'h77, 8, 0, 0, 0, 0, 1, 1);
    pop_expect("R11 re-enabled", 12'h077);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    hold(1'b1, BIT_CLKS);
    t_reset();
    t_basic();
    t_wordlen();
    t_parity();
    t_stop2();
    t_framing();
    t_break();
    t_glitch();
    t_overrun();
    t_holding();
    t_disabled();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule